// File: doc/BRIEF.md
# Monitor Limit Comparator with Sticky Flags and Maskable Interrupt

This block watches five digitised monitor results: a temperature reading, a supply voltage reading and three external monitor readings. Each result is a 13-bit value held left-justified in a 16-bit word. The temperature word is two's complement and the other four are unsigned. Each time a channel presents a new result with its valid strobe, the block compares that result with four programmable limits: an alarm ceiling, an alarm floor, a warning ceiling and a warning floor. A result that lies outside a limit sets the matching sticky flag.

The flags gather into an alarm flag pair and a warning flag pair. One interrupt output is the OR of every flag whose mask bit is set. Any mix of alarm and warning flags may be enabled. A host reaches the limits, the latched results, the flags and the masks through a byte-wide register port. Reads return data one cycle after the address is presented. Flags are cleared by writing ones to them.

Top module: `mon_limit_guard`

## Requirements
- R1: After reset every flag and every mask bit is 0 and `irq` is 0. The temperature limits reset to 0x7FFF for both ceilings and 0x8000 for both floors. The other channels' ceilings reset to 0xFFFF and their floors to 0x0000.
- R2: Channel c (0 = temperature, 1 = supply, 2..4 = monitors 1..3) has its limits at byte address c*8 + s*2 + b. The slot s is 0 for the alarm ceiling, 1 for the alarm floor, 2 for the warning ceiling and 3 for the warning floor. Byte b=0 holds bits 15:8 and b=1 holds bits 7:0. Every limit byte reads back what was last written to it.
- R3: The temperature channel compares as two's complement. For example, 0xF000 lies below a floor of 0x0000 and does not exceed a ceiling of 0x1900.
- R4: The supply and monitor channels compare as unsigned. For example, 0xF000 exceeds a ceiling of 0x8000.
- R5: A ceiling flag sets only when the result is strictly greater than the ceiling. A floor flag sets only when the result is strictly less than the floor. A result equal to a limit sets nothing.
- R6: Comparisons happen only in a cycle where that channel's `res_valid` bit is high. A result word presented without its strobe sets no flag and does not change the latched result.
- R7: A set flag stays set until the host writes a 1 to its bit. Writing 0 leaves it set.
- R8: Flag index k = 2c + h, with h=0 for the ceiling flag and h=1 for the floor flag, sits at bit 15-k of a 16-bit flag word. Bits 15:8 of that word are at the first address of the pair and bits 7:0 at the next. Alarm flags are at 0x70/0x71 and warning flags at 0x74/0x75. For example, the temperature floor flag is bit 6 of 0x70, and the monitor 3 floor flag is bit 6 of 0x71 or 0x75.
- R9: The alarm mask at 0x78/0x79 and the warning mask at 0x7C/0x7D use the same bit layout as the flags. `irq` is high exactly when a flag and its mask bit are both 1. `irq` drops in the cycle after the write that clears the last enabled flag or its mask bit.
- R10: When a flag's set condition and a host clear of that same flag fall in the same cycle, the flag ends up set.
- R11: Each strobed result is latched. Channel c's latched result reads at 0x60 + 2c (bits 15:8) and 0x61 + 2c (bits 7:0).
- R12: `hst_rdata` is registered. It shows the data for the address presented at a rising edge after that edge, and does not follow an address change before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 5 | Per-channel result strobe, bit c for channel c |
| res_word | input | 80 | Results; channel c at bits [16c+15:16c] |
| hst_we | input | 1 | Host write enable for this cycle |
| hst_addr | input | 8 | Host byte address for read or write |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Interrupt: OR of masked alarm and warning flags |

## Verification
On every cycle the assertions check the following. Flags never drop without a clear and never rise without a set condition. A set beats a simultaneous clear. Limits, masks and latched results change only through a write or a strobe. A result equal to a ceiling never raises a flag. `irq` falls only after a host write. The bench scenarios are needed to show the comparison results themselves. They cover signed versus unsigned ordering across the sign bit, the exact flag bit positions, the address map, the reset values of the limits, the read latency, and `irq` following the mask for both severities.

// File: rtl/mlg_pkg.sv
package mlg_pkg;
  // register block base addresses (byte-wide host port)
  localparam logic [7:0] A_RES  = 8'h60;
  localparam logic [7:0] A_AFLG = 8'h70;
  localparam logic [7:0] A_WFLG = 8'h74;
  localparam logic [7:0] A_AMSK = 8'h78;
  localparam logic [7:0] A_WMSK = 8'h7C;

  // limit slot order inside one channel
  typedef enum logic [1:0] {
    LIM_AHI = 2'd0,
    LIM_ALO = 2'd1,
    LIM_WHI = 2'd2,
    LIM_WLO = 2'd3
  } lim_slot_e;

  localparam int SLOTS = 4;
  localparam int FW    = 16; // flag word width in the map
endpackage

// File: rtl/mlg_chan_cmp.sv
module mlg_chan_cmp #(
  parameter int DW         = 16,
  parameter bit SIGNED_CMP = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic [DW-1:0] res,
  input  logic [DW-1:0] lim_ahi,
  input  logic [DW-1:0] lim_alo,
  input  logic [DW-1:0] lim_whi,
  input  logic [DW-1:0] lim_wlo,
  output logic [1:0]    aset,   // [0] ceiling, [1] floor
  output logic [1:0]    wset,
  output logic [DW-1:0] res_q
);
  logic gt_ah, lt_al, gt_wh, lt_wl;

  generate
    if (SIGNED_CMP) begin : g_signed
      assign gt_ah = $signed(res) > $signed(lim_ahi);
      assign lt_al = $signed(res) < $signed(lim_alo);
      assign gt_wh = $signed(res) > $signed(lim_whi);
      assign lt_wl = $signed(res) < $signed(lim_wlo);
    end else begin : g_unsigned
      assign gt_ah = res > lim_ahi;
      assign lt_al = res < lim_alo;
      assign gt_wh = res > lim_whi;
      assign lt_wl = res < lim_wlo;
    end
  endgenerate

  assign aset = valid ? {lt_al, gt_ah} : 2'b00;
  assign wset = valid ? {lt_wl, gt_wh} : 2'b00;

  always_ff @(posedge clk) begin
    if (rst)        res_q <= '0;
    else if (valid) res_q <= res;
  end

  AST_EQ_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (valid && res == lim_ahi) |-> !aset[0]); // R5
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(res_q)); // R11
endmodule

// File: rtl/mlg_flags.sv
module mlg_flags #(
  parameter int NF = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] aset,
  input  logic [NF-1:0] wset,
  input  logic [NF-1:0] aclr,
  input  logic [NF-1:0] wclr,
  input  logic [NF-1:0] amask,
  input  logic [NF-1:0] wmask,
  output logic [NF-1:0] alm_q,
  output logic [NF-1:0] wrn_q,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      alm_q <= '0;
      wrn_q <= '0;
    end else begin
      alm_q <= (alm_q & ~aclr) | aset;
      wrn_q <= (wrn_q & ~wclr) | wset;
    end
  end

  assign irq = |((alm_q & amask) | (wrn_q & wmask));

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(alm_q) & ~$past(aclr)) & ~alm_q) == '0) &&
             ((($past(wrn_q) & ~$past(wclr)) & ~wrn_q) == '0)); // R7
  AST_FLAG_NEEDS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((alm_q & ~$past(alm_q) & ~$past(aset)) == '0) &&
             ((wrn_q & ~$past(wrn_q) & ~$past(wset)) == '0)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|(aset | wset)) |=> ((alm_q & $past(aset)) == $past(aset)) &&
                         ((wrn_q & $past(wset)) == $past(wset))); // R10
endmodule

// File: rtl/mlg_regs.sv
module mlg_regs
  import mlg_pkg::*;
#(
  parameter int             NCH       = 5,
  parameter int             DW        = 16,
  parameter logic [NCH-1:0] SIGNED_CH = 'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [7:0]             addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [2*NCH-1:0]       alm,
  input  logic [2*NCH-1:0]       wrn,
  input  logic [NCH*DW-1:0]      res_flat,
  output logic [NCH*SLOTS*DW-1:0] lim_flat,
  output logic [2*NCH-1:0]       amask,
  output logic [2*NCH-1:0]       wmask,
  output logic [2*NCH-1:0]       aclr,
  output logic [2*NCH-1:0]       wclr
);
  localparam int         NF        = 2 * NCH;
  localparam int         NB        = DW / 8;
  localparam int         LIM_WORDS = NCH * SLOTS;
  localparam int         IW        = $clog2(LIM_WORDS);
  localparam logic [7:0] LIM_END   = 8'(LIM_WORDS * NB);
  localparam logic [7:0] RES_END   = 8'(int'(A_RES) + NCH * NB);

  logic [DW-1:0] lim_q [LIM_WORDS];
  logic [NF-1:0] amask_q, wmask_q;
  logic [FW-1:0] aw, ww, amw, wmw;
  logic [IW-1:0] widx;
  int            bsel, rbase;
  logic [7:0]    rd_next;

  function automatic logic [FW-1:0] to_word(input logic [NF-1:0] f);
    to_word = '0;
    for (int k = 0; k < NF; k++) to_word[FW-1-k] = f[k];
  endfunction

  function automatic logic [NF-1:0] from_word(input logic [FW-1:0] w);
    for (int k = 0; k < NF; k++) from_word[k] = w[FW-1-k];
  endfunction

  function automatic logic [FW-1:0] put_byte(input logic [FW-1:0] w,
                                             input logic lo, input logic [7:0] d);
    put_byte = lo ? {w[15:8], d} : {d, w[7:0]};
  endfunction

  function automatic logic [DW-1:0] lim_rst(input int i);
    logic sgn, hi;
    sgn = SIGNED_CH[i / SLOTS];
    hi  = ((i % SLOTS) == int'(LIM_AHI)) || ((i % SLOTS) == int'(LIM_WHI));
    if (sgn) lim_rst = hi ? {1'b0, {(DW-1){1'b1}}} : {1'b1, {(DW-1){1'b0}}};
    else     lim_rst = hi ? {DW{1'b1}} : {DW{1'b0}};
  endfunction

  assign aw  = to_word(alm);
  assign ww  = to_word(wrn);
  assign amw = to_word(amask_q);
  assign wmw = to_word(wmask_q);

  always_comb begin
    widx  = IW'(int'(addr) / NB);
    bsel  = int'(addr) % NB;
    rbase = ((int'(addr) - int'(A_RES)) / NB) * DW + DW - 1 - 8 * ((int'(addr) - int'(A_RES)) % NB);
  end

  // write-one-to-clear pulses for the flag bytes
  always_comb begin
    aclr = '0;
    wclr = '0;
    if (we) begin
      if (addr == A_AFLG)      aclr = from_word({wdata, 8'h00});
      if (addr == A_AFLG + 1)  aclr = from_word({8'h00, wdata});
      if (addr == A_WFLG)      wclr = from_word({wdata, 8'h00});
      if (addr == A_WFLG + 1)  wclr = from_word({8'h00, wdata});
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr < LIM_END)
      rd_next = lim_q[widx][DW-1-8*bsel -: 8];
    else if (addr >= A_RES && addr < RES_END)
      rd_next = res_flat[rbase -: 8];
    else begin
      case (addr)
        A_AFLG:     rd_next = aw[15:8];
        A_AFLG + 1: rd_next = aw[7:0];
        A_WFLG:     rd_next = ww[15:8];
        A_WFLG + 1: rd_next = ww[7:0];
        A_AMSK:     rd_next = amw[15:8];
        A_AMSK + 1: rd_next = amw[7:0];
        A_WMSK:     rd_next = wmw[15:8];
        A_WMSK + 1: rd_next = wmw[7:0];
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LIM_WORDS; i++) lim_q[i] <= lim_rst(i);
      amask_q <= '0;
      wmask_q <= '0;
      rdata   <= '0;
    end else begin
      if (we) begin
        if (addr < LIM_END) lim_q[widx][DW-1-8*bsel -: 8] <= wdata;
        if (addr == A_AMSK || addr == A_AMSK + 1)
          amask_q <= from_word(put_byte(amw, addr[0], wdata));
        if (addr == A_WMSK || addr == A_WMSK + 1)
          wmask_q <= from_word(put_byte(wmw, addr[0], wdata));
      end
      rdata <= rd_next;
    end
  end

  always_comb
    for (int i = 0; i < LIM_WORDS; i++) lim_flat[i*DW +: DW] = lim_q[i];

  assign amask = amask_q;
  assign wmask = wmask_q;

  AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(lim_flat)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(amask_q) && $stable(wmask_q))); // R9
endmodule

// File: rtl/mon_limit_guard.sv
module mon_limit_guard
  import mlg_pkg::*;
#(
  parameter int             NCH       = 5,
  parameter int             DW        = 16,
  parameter logic [NCH-1:0] SIGNED_CH = 'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    res_valid,
  input  logic [NCH*DW-1:0] res_word,
  input  logic              hst_we,
  input  logic [7:0]        hst_addr,
  input  logic [7:0]        hst_wdata,
  output logic [7:0]        hst_rdata,
  output logic              irq
);
  localparam int NF = 2 * NCH;

  logic [NCH*SLOTS*DW-1:0] lim_flat;
  logic [NCH*DW-1:0]       res_flat;
  logic [NF-1:0]           aset, wset, aclr, wclr, amask, wmask, alm_q, wrn_q;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      mlg_chan_cmp #(
        .DW        (DW),
        .SIGNED_CMP(SIGNED_CH[c])
      ) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .valid  (res_valid[c]),
        .res    (res_word[c*DW +: DW]),
        .lim_ahi(lim_flat[(c*SLOTS + int'(LIM_AHI))*DW +: DW]),
        .lim_alo(lim_flat[(c*SLOTS + int'(LIM_ALO))*DW +: DW]),
        .lim_whi(lim_flat[(c*SLOTS + int'(LIM_WHI))*DW +: DW]),
        .lim_wlo(lim_flat[(c*SLOTS + int'(LIM_WLO))*DW +: DW]),
        .aset   (aset[2*c +: 2]),
        .wset   (wset[2*c +: 2]),
        .res_q  (res_flat[c*DW +: DW])
      );
    end
  endgenerate

  mlg_regs #(
    .NCH      (NCH),
    .DW       (DW),
    .SIGNED_CH(SIGNED_CH)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (hst_we),
    .addr    (hst_addr),
    .wdata   (hst_wdata),
    .rdata   (hst_rdata),
    .alm     (alm_q),
    .wrn     (wrn_q),
    .res_flat(res_flat),
    .lim_flat(lim_flat),
    .amask   (amask),
    .wmask   (wmask),
    .aclr    (aclr),
    .wclr    (wclr)
  );

  mlg_flags #(.NF(NF)) u_flags (
    .clk  (clk),
    .rst  (rst),
    .aset (aset),
    .wset (wset),
    .aclr (aclr),
    .wclr (wclr),
    .amask(amask),
    .wmask(wmask),
    .alm_q(alm_q),
    .wrn_q(wrn_q),
    .irq  (irq)
  );

  AST_IRQ_FALL_BY_HOST: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(hst_we)); // R9
endmodule

// File: tb/mon_limit_guard_tb_top.sv
module mon_limit_guard_tb_top;
  localparam int NCH = 5;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    res_valid = '0;
  logic [NCH*DW-1:0] res_word = '0;
  logic              hst_we = 1'b0;
  logic [7:0]        hst_addr = '0;
  logic [7:0]        hst_wdata = '0;
  logic [7:0]        hst_rdata;
  logic              irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mon_limit_guard #(.NCH(NCH), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_word(res_word),
    .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_we = 1'b0; hst_addr = a;
    @(negedge clk);
    d = hst_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic push(input int ch, input logic [15:0] w);
    @(negedge clk);
    res_valid = '0; res_valid[ch] = 1'b1; res_word[ch*DW +: DW] = w;
    @(negedge clk);
    res_valid = '0;
  endtask

  task automatic clear_all();
    wr(8'h70, 8'hFF); wr(8'h71, 8'hFF); wr(8'h74, 8'hFF); wr(8'h75, 8'hFF);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {15'd0, irq}, 16'd0);
    rd_chk("R1 alarm flags 0x70", 8'h70, 8'h00);
    rd_chk("R1 alarm flags 0x71", 8'h71, 8'h00);
    rd_chk("R1 warn flags 0x74", 8'h74, 8'h00);
    rd_chk("R1 warn flags 0x75", 8'h75, 8'h00);
    rd_chk("R1 alarm mask 0x78", 8'h78, 8'h00);
    rd_chk("R1 warn mask 0x7D", 8'h7D, 8'h00);
    rd_chk("R1 temp ceiling msb", 8'h00, 8'h7F);
    rd_chk("R1 temp ceiling lsb", 8'h01, 8'hFF);
    rd_chk("R1 temp floor msb", 8'h02, 8'h80);
    rd_chk("R1 temp warn ceiling msb", 8'h04, 8'h7F);
    rd_chk("R1 supply ceiling msb", 8'h08, 8'hFF);
    rd_chk("R1 supply floor lsb", 8'h0B, 8'h00);
  endtask

  task automatic t_read_latency();
    rd_chk("R12 read 0x00", 8'h00, 8'h7F);
    @(negedge clk);
    hst_addr = 8'h02;
    #1;
    chk("R12 rdata holds before edge", {8'h00, hst_rdata}, 16'h007F);
    @(negedge clk);
    chk("R12 rdata after edge", {8'h00, hst_rdata}, 16'h0080);
  endtask

  task automatic t_limits();
    wr(8'h14, 8'h12); wr(8'h15, 8'h34);
    rd_chk("R2 mon1 warn ceiling msb", 8'h14, 8'h12);
    rd_chk("R2 mon1 warn ceiling lsb", 8'h15, 8'h34);
    rd_chk("R2 neighbour untouched", 8'h16, 8'h00);
  endtask

  task automatic t_temp_signed();
    wr(8'h00, 8'h19); wr(8'h01, 8'h00); wr(8'h02, 8'h00); wr(8'h03, 8'h00);
    push(0, 16'hF000);
    rd_chk("R3 negative temp sets floor only", 8'h70, 8'h40);
    rd_chk("R3 no temp warning", 8'h74, 8'h00);
    wr(8'h70, 8'h40);
    rd_chk("R7 clear temp floor", 8'h70, 8'h00);
    push(0, 16'h1A00);
    rd_chk("R3 R8 temp ceiling bit7", 8'h70, 8'h80);
  endtask

  task automatic t_unsigned();
    clear_all();
    wr(8'h08, 8'h80); wr(8'h09, 8'h00); wr(8'h0A, 8'h10); wr(8'h0B, 8'h00);
    push(1, 16'hF000);
    rd_chk("R4 supply 0xF000 above 0x8000", 8'h70, 8'h20);
    push(1, 16'h0800);
    rd_chk("R4 R8 supply floor bit4", 8'h70, 8'h30);
    wr(8'h26, 8'h20); wr(8'h27, 8'h00);
    push(4, 16'h1000);
    rd_chk("R8 mon3 warn floor 0x75 bit6", 8'h75, 8'h40);
    rd_chk("R8 mon3 alarm clear", 8'h71, 8'h00);
  endtask

  task automatic t_equal();
    clear_all();
    wr(8'h18, 8'h40); wr(8'h19, 8'h00);
    push(3, 16'h4000);
    push(0, 16'h1900);
    rd_chk("R5 equal to ceiling no flag 0x70", 8'h70, 8'h00);
    rd_chk("R5 equal no flag 0x71", 8'h71, 8'h00);
    push(3, 16'h4008);
    rd_chk("R5 R8 mon2 ceiling bit1", 8'h70, 8'h02);
  endtask

  task automatic t_no_valid();
    clear_all();
    @(negedge clk);
    res_word[1*DW +: DW] = 16'hFFFF;
    res_word[0*DW +: DW] = 16'h7000;
    repeat (3) @(negedge clk);
    rd_chk("R6 no strobe no flag", 8'h70, 8'h00);
    rd_chk("R6 R11 latched supply msb kept", 8'h62, 8'h08);
    rd_chk("R11 latched supply lsb", 8'h63, 8'h00);
  endtask

  task automatic t_sticky();
    push(1, 16'hF000);
    push(1, 16'h2000);
    rd_chk("R7 flag stays after in-range result", 8'h70, 8'h20);
    wr(8'h70, 8'h00);
    rd_chk("R7 write zero keeps flag", 8'h70, 8'h20);
    wr(8'h70, 8'h20);
    rd_chk("R7 write one clears", 8'h70, 8'h00);
  endtask

  task automatic t_irq();
    clear_all();
    wr(8'h78, 8'h80);
    chk("R9 irq low with mask only", {15'd0, irq}, 16'd0);
    push(0, 16'h1A00);
    chk("R9 irq on masked temp ceiling", {15'd0, irq}, 16'd1);
    wr(8'h70, 8'h80);
    chk("R9 irq drops after clear", {15'd0, irq}, 16'd0);
    push(1, 16'hF000);
    chk("R9 unmasked flag no irq", {15'd0, irq}, 16'd0);
    wr(8'h7D, 8'h40);
    rd_chk("R9 warn mask readback", 8'h7D, 8'h40);
    push(4, 16'h1000);
    chk("R9 irq from warning", {15'd0, irq}, 16'd1);
    wr(8'h75, 8'h40);
    chk("R9 irq drops after warning clear", {15'd0, irq}, 16'd0);
    wr(8'h78, 8'h00); wr(8'h7D, 8'h00);
    clear_all();
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    res_valid = 5'b00001; res_word[0 +: DW] = 16'h1A00;
    hst_we = 1'b1; hst_addr = 8'h70; hst_wdata = 8'h80;
    @(negedge clk);
    res_valid = '0; hst_we = 1'b0;
    rd_chk("R10 set beats clear", 8'h70, 8'h80);
    wr(8'h70, 8'h80);
    rd_chk("R10 plain clear", 8'h70, 8'h00);
  endtask

  task automatic t_result();
    push(2, 16'hABC8);
    rd_chk("R11 mon1 result msb", 8'h64, 8'hAB);
    rd_chk("R11 mon1 result lsb", 8'h65, 8'hC8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_latency();
    t_limits();
    t_temp_signed();
    t_unsigned();
    t_equal();
    t_no_valid();
    t_sticky();
    t_irq();
    t_set_wins();
    t_result();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule